// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter

This block shares one bus among four masters: a processor, two DMA engines and a USB controller. Each master asks for the bus on its own request line. The arbiter answers with a one-hot grant. The grant stays with its owner until the end-of-transfer strobe arrives. The bus therefore carries whole transfers, and the arbiter needs no knowledge of burst lengths.

Every master has a small priority register, written through a simple write port. The register holds a value from 1 to 4, where 1 is the most urgent. Out of reset all four registers hold the same value, so the masters take turns in strict rotation. Once different values are programmed, the most urgent requesters win. Among requesters that share the best value, the turn passes to the first one found after the master granted most recently.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset the grant is all zero and every priority register holds 4, so the first round of requests from all masters is served in the order master 0, 1, 2, 3.
- R2: When all priorities are equal, the winner is the first requesting master after the most recently granted one, counting upward and wrapping from 3 to 0.
- R3: When requesters hold different priorities, the grant goes to a requester with the numerically lowest value, where 1 is the most urgent and 4 the least.
- R4: Ties among requesters at the best value are broken by the rotation of R2, starting after the last granted master, whatever that master's own priority.
- R5: Once issued, a grant stays unchanged until `xfer_done` is sampled high, regardless of request changes or priority writes.
- R6: The clock edge that samples `xfer_done` high while a grant is held clears the grant. At the next edge, a new grant is issued from the requests present in the cycle between.
- R7: A priority write stores its 3-bit value to the master selected by `prio_wr_sel` (0..3) on the clock edge. A value of 0, or any value above 4, is stored as 4.
- R8: With no request active, no grant is issued and the rotation pointer keeps its value.
- R9: `grant` is always one-hot or all zero. Bit i belongs to master i.
- R10: A new grant is only given to a master whose request was high in the cycle in which the decision was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request lines, bit i for master i |
| prio_wr_en | input | 1 | Priority register write strobe |
| prio_wr_sel | input | 2 | Index of the master whose priority is written |
| prio_wr_data | input | 3 | Priority value to store (clamped per R7) |
| xfer_done | input | 1 | End of the current transfer; releases the grant |
| grant | output | 4 | One-hot grant, bit i for master i |

## Verification
Arbitration is first driven with all four masters requesting at equal priority, and then with sparse request masks. This separates a true rotation from a fixed-order encoder, and shows whether idle cycles disturb the pointer. Mixed priority maps are then applied. One case places the tie group so that only a pointer taken from the last grant, and not one kept per priority level, gives the expected winner. Out-of-range writes are chosen so that an unclamped value of 0 or 5 would change the winner. The hold test changes requests and raises another master's urgency while a grant is held, which shows whether ownership can be taken away before the end-of-transfer strobe.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_MASTERS = 4;
    localparam int PRIO_W      = 3;
    localparam int PRIO_MAX    = 4;
    localparam int IDX_W       = $clog2(NUM_MASTERS);

    typedef logic [NUM_MASTERS-1:0]             mask_t;
    typedef logic [PRIO_W-1:0]                  prio_t;
    typedef logic [IDX_W-1:0]                   idx_t;
    typedef logic [NUM_MASTERS-1:0][PRIO_W-1:0] prio_arr_t;

    typedef enum logic {
        ARB_FREE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    // Map an arbitrary written value into the legal 1..PRIO_MAX range.
    function automatic prio_t clamp_prio(input prio_t raw);
        if (raw == '0 || int'(raw) > PRIO_MAX)
            return prio_t'(PRIO_MAX);
        return raw;
    endfunction

    function automatic mask_t idx_to_onehot(input idx_t idx);
        mask_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs
    import arb_pkg::*;
#(
    parameter int N = NUM_MASTERS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  idx_t      wr_sel,
    input  prio_t     wr_data,
    output prio_arr_t prio_o
);

    prio_t wr_clamped;
    assign wr_clamped = clamp_prio(wr_data);

    for (genvar i = 0; i < N; i++) begin : g_reg
        prio_t prio_q;

        always_ff @(posedge clk) begin
            if (rst)
                prio_q <= prio_t'(PRIO_MAX);
            else if (wr_en && wr_sel == idx_t'(i))
                prio_q <= wr_clamped;
        end

        assign prio_o[i] = prio_q;

        // R7: stored value is always inside the legal range
        p_prio_range_r7: assert property (@(posedge clk) disable iff (rst)
            (prio_q != '0) && (int'(prio_q) <= PRIO_MAX));

        // R7: an out-of-range write lands as the lowest urgency
        p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == idx_t'(i) && (wr_data == '0 || int'(wr_data) > PRIO_MAX))
            |=> (prio_q == prio_t'(PRIO_MAX)));
    end

endmodule

// File: rtl/arb_select.sv
module arb_select
    import arb_pkg::*;
#(
    parameter int N = NUM_MASTERS
) (
    input  mask_t     req,
    input  prio_arr_t prio,
    input  idx_t      last,
    output pick_t     pick
);

    prio_t best;
    mask_t elig;

    // Most urgent value among active requesters
    always_comb begin
        best = prio_t'(PRIO_MAX);
        for (int i = 0; i < N; i++) begin
            if (req[i] && prio[i] < best)
                best = prio[i];
        end
    end

    // Requesters sharing that value form the candidate set
    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = req[i] && (prio[i] == best);
    end

    // Rotate starting just after the last owner
    always_comb begin
        pick = '0;
        for (int off = 1; off <= N; off++) begin
            int k;
            k = (int'(last) + off) % N;
            if (!pick.valid && elig[k]) begin
                pick.valid = 1'b1;
                pick.idx   = idx_t'(k);
            end
        end
    end

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
    import arb_pkg::*;
#(
    parameter int N = NUM_MASTERS
) (
    input  logic  clk,
    input  logic  rst,
    input  mask_t req,
    input  logic  xfer_done,
    input  pick_t pick,
    output idx_t  last_o,
    output mask_t grant_o
);

    arb_state_e state_q;
    idx_t       last_q;
    mask_t      grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_FREE;
            last_q  <= idx_t'(N - 1);
            grant_q <= '0;
        end else begin
            unique case (state_q)
                ARB_FREE: begin
                    if (pick.valid) begin
                        grant_q <= idx_to_onehot(pick.idx);
                        last_q  <= pick.idx;
                        state_q <= ARB_OWNED;
                    end
                end
                ARB_OWNED: begin
                    if (xfer_done) begin
                        grant_q <= '0;
                        state_q <= ARB_FREE;
                    end
                end
                default: state_q <= ARB_FREE;
            endcase
        end
    end

    assign last_o  = last_q;
    assign grant_o = grant_q;

    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0 && !xfer_done) |=> (grant_o == $past(grant_o)));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0 && xfer_done) |=> (grant_o == '0));

    p_decide_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && req != '0) |=> (grant_o != '0));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && req == '0) |=> (grant_o == '0 && $stable(last_q)));

    p_to_requester_r10: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && req != '0) |=> ((grant_o & $past(req)) != '0));

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int N = NUM_MASTERS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req,
    input  logic              prio_wr_en,
    input  logic [IDX_W-1:0]  prio_wr_sel,
    input  logic [PRIO_W-1:0] prio_wr_data,
    input  logic              xfer_done,
    output logic [N-1:0]      grant
);

    prio_arr_t prio_map;
    idx_t      last_idx;
    pick_t     pick;

    arb_prio_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prio_wr_en),
        .wr_sel  (prio_wr_sel),
        .wr_data (prio_wr_data),
        .prio_o  (prio_map)
    );

    arb_select #(.N(N)) u_select (
        .req  (req),
        .prio (prio_map),
        .last (last_idx),
        .pick (pick)
    );

    arb_grant_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .xfer_done (xfer_done),
        .pick      (pick),
        .last_o    (last_idx),
        .grant_o   (grant)
    );

endmodule

// File: tb/tb_prio_bus_arbiter.sv
module tb_prio_bus_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic       prio_wr_en = 1'b0;
    logic [1:0] prio_wr_sel = '0;
    logic [2:0] prio_wr_data = '0;
    logic       xfer_done = 1'b0;
    logic [3:0] grant;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    prio_bus_arbiter dut (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .prio_wr_en   (prio_wr_en),
        .prio_wr_sel  (prio_wr_sel),
        .prio_wr_data (prio_wr_data),
        .xfer_done    (xfer_done),
        .grant        (grant)
    );

    task automatic check_grant(input logic [3:0] exp, input string tag);
        checks++;
        if (grant !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
        checks++;
        if (!$onehot0(grant)) begin
            failures++;
            $display("FAIL R9 grant actual=%b expected=one-hot or zero", grant);
        end
    endtask

    task automatic write_prio(input int sel, input int val);
        prio_wr_en   = 1'b1;
        prio_wr_sel  = 2'(sel);
        prio_wr_data = 3'(val);
        @(negedge clk);
        prio_wr_en   = 1'b0;
    endtask

    // Issue a request mask from idle, check the winner, then release it.
    task automatic serve(input logic [3:0] mask, input logic [3:0] exp, input string tag);
        req = mask;
        @(negedge clk);
        check_grant(exp, tag);
        checks++;
        if ((grant & mask) == '0) begin
            failures++;
            $display("FAIL R10 grant actual=%b expected a bit of req=%b", grant, mask);
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        req = '0;
        check_grant(4'b0000, "R6 release");
    endtask

    task automatic t_reset();
        check_grant(4'b0000, "R1 reset");
    endtask

    task automatic t_round_robin();
        serve(4'b1111, 4'b0001, "R1 first m0");
        serve(4'b1111, 4'b0010, "R2 rr m1");
        serve(4'b1111, 4'b0100, "R2 rr m2");
        serve(4'b1111, 4'b1000, "R2 rr m3");
        serve(4'b1111, 4'b0001, "R2 wrap m0");
        serve(4'b1010, 4'b0010, "R2 sparse m1");
        serve(4'b1010, 4'b1000, "R2 sparse m3");
        serve(4'b1010, 4'b0010, "R2 sparse wrap m1");
    endtask

    task automatic t_no_request();
        req = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_grant(4'b0000, "R8 idle");
        end
        serve(4'b1111, 4'b0100, "R8 pointer kept m2");
    endtask

    task automatic t_priority();
        write_prio(3, 1);
        serve(4'b1111, 4'b1000, "R3 m3 urgent");
        serve(4'b1111, 4'b1000, "R3 m3 again");
        write_prio(0, 3);
        write_prio(1, 2);
        write_prio(2, 4);
        write_prio(3, 4);
        serve(4'b1111, 4'b0010, "R3 m1 best");
        serve(4'b1101, 4'b0001, "R3 m0 best");
        serve(4'b1100, 4'b0100, "R4 tie after m0");
    endtask

    task automatic t_tie();
        write_prio(0, 1);
        write_prio(2, 1);
        serve(4'b1111, 4'b0001, "R4 tie m0");
        serve(4'b1111, 4'b0100, "R4 tie m2");
        serve(4'b1111, 4'b0001, "R4 tie m0 again");
    endtask

    task automatic t_clamp();
        write_prio(0, 0);
        write_prio(1, 3);
        write_prio(2, 5);
        write_prio(3, 4);
        serve(4'b0011, 4'b0010, "R7 zero clamped");
        serve(4'b1100, 4'b0100, "R7 five clamped");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) write_prio(i, 4);
        req = 4'b0001;
        @(negedge clk);
        check_grant(4'b0001, "R5 owner m0");
        req = 4'b1110;
        prio_wr_en = 1'b1; prio_wr_sel = 2'd3; prio_wr_data = 3'd1;
        @(negedge clk);
        prio_wr_en = 1'b0;
        check_grant(4'b0001, "R5 hold under write");
        @(negedge clk);
        check_grant(4'b0001, "R5 hold under requests");
        req = '0;
        @(negedge clk);
        check_grant(4'b0001, "R5 hold without request");
        req = 4'b1110;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check_grant(4'b0000, "R6 gap after done");
        @(negedge clk);
        check_grant(4'b1000, "R6 next decision m3");
        xfer_done = 1'b1;
        req = '0;
        @(negedge clk);
        xfer_done = 1'b0;
        check_grant(4'b0000, "R6 final release");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_round_robin();
        t_no_request();
        t_priority();
        t_tie();
        t_clamp();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule